// File: doc/BRIEF.md
# Utility-Driven Cache Way Partitioner

This block divides the ways of a shared set-associative cache between two cores according to how much each core would gain from extra capacity. For each core it keeps a small shadow tag directory over a handful of sampled sets. The directory models an LRU stack, and a counter per stack depth records how often a hit landed at that depth. Because LRU is a stack algorithm, the sum of the shallowest n counters is the hit count that core would see with n ways. One pass over the counters therefore prices every possible split.

Once per epoch the counters are frozen into a snapshot, and the live counters are halved so that recent behaviour carries the most weight. A sequencer then scores one candidate split per cycle and keeps the best. When the last candidate has been scored, both quotas change together and a one-cycle done pulse is raised. Between epochs the block acts as a combinational victim picker for the main cache. The main cache gives it the missing core, the owner bit of each way and each way's LRU rank, and it returns the way to evict, so that each core drifts toward its quota.

Top module: `way_partitioner`

## Requirements
- R1: After reset both quotas equal WAYS/2 and the done output is low.
- R2: An access with valid and sampled flags set updates only the requesting core's shadow stack for the given sampled set. A hit at stack depth p, where 0 is most recent, adds one to that core's counter p and moves the tag to depth 0. A miss inserts the tag at depth 0, pushes the others down and drops the deepest one. An access without the sampled flag changes nothing.
- R3: Each depth counter saturates at 2^CNT_W-1 and never wraps.
- R4: Every EPOCH_LEN cycles the counters are copied into a snapshot before any change, and the live counters are replaced by their value halved and rounded down. A hit in that same cycle adds one to the halved value.
- R5: The evaluation scores every a from 1 to WAYS-1 as the sum of core 0's counters 0..a-1 and core 1's counters 0..WAYS-a-1, both taken from the snapshot. It picks the a with the largest score, and the smallest such a when scores tie.
- R6: Done is a one-cycle pulse that appears WAYS-1 cycles after the snapshot edge, so the first one is seen after clock edge EPOCH_LEN+WAYS-1 following reset. The quotas change only in that cycle. quota0 becomes the chosen a, quota1 becomes WAYS-a, and each quota is always at least 1.
- R7: For the victim port, bit w of the owner vector names the core (0 or 1) that owns way w. Rank field w, at bits w*log2(WAYS) upward, is the LRU rank of that way, with 0 most recent and WAYS-1 least recent. If the number of ways owned by the missing core is below its quota, the victim is the highest-ranked way owned by the other core.
- R8: Otherwise the victim is the highest-ranked way owned by the missing core.
- R9: Among equally ranked candidates the victim is the lowest way index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access present this cycle |
| accCore | input | 1 | Requesting core |
| accSampled | input | 1 | Access falls in a sampled set |
| accSet | input | log2(SAMPLE_SETS) | Sampled set number |
| accTag | input | TAG_W | Access tag |
| vicCore | input | 1 | Core that missed in the main cache |
| vicOwner | input | WAYS | Owner core of each way in the missing set |
| vicRank | input | WAYS*log2(WAYS) | LRU rank of each way |
| vicWay | output | log2(WAYS) | Way to evict |
| quota0 | output | log2(WAYS+1) | Ways granted to core 0 |
| quota1 | output | log2(WAYS+1) | Ways granted to core 1 |
| evalDone | output | 1 | Pulse marking a new pair of quotas |

## Verification
The assertions check on every cycle that the quotas sum to the way count and never fall below one, that they move only with the commit strobe, and that done lasts a single cycle. They also check that a counter never drops except at a halving, never climbs by more than one, and stays put when its core is idle. Each victim must come from the class the ownership count and quota call for. Only the bench's scenarios can show that the stack depth is counted correctly, that saturation and halving steer the choice of split, and that ties go to the smallest split. They also show that accesses without the sampled flag leave the result alone and that the epoch timing and rank tie-break come out exactly.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic snap;       // freeze counters into the snapshot, halve live counters
    logic evalStep;   // a candidate split is being scored this cycle
    logic evalFirst;  // first candidate: load best unconditionally
    logic evalLast;   // last candidate: commit quotas
  } wpStrobe_t;
endpackage

// File: rtl/wp_monitor.sv
module wp_monitor #(
  parameter int WAYS  = 16,
  parameter int SETS  = 32,
  parameter int TAG_W = 16,
  parameter int CNT_W = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int POS_W = $clog2(WAYS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            accEn,
  input  logic [SET_W-1:0]                accSet,
  input  logic [TAG_W-1:0]                accTag,
  input  logic                            halve,
  output logic [WAYS-1:0][CNT_W-1:0]      hitCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Shadow directory: entry 0 is most recent, entry WAYS-1 least recent.
  logic [TAG_W-1:0] atdTag [SETS][WAYS];
  logic [WAYS-1:0]  atdVal [SETS];

  logic [WAYS-1:0]  hitVec;
  logic             isHit;
  logic [POS_W-1:0] hitPos;
  logic [POS_W-1:0] shiftLim;
  logic [WAYS-1:0][CNT_W-1:0] nextCnt;

  always_comb begin
    isHit  = 1'b0;
    hitPos = '0;
    for (int w = 0; w < WAYS; w++)
      hitVec[w] = atdVal[accSet][w] && (atdTag[accSet][w] == accTag);
    for (int w = WAYS-1; w >= 0; w--)
      if (hitVec[w]) begin
        isHit  = 1'b1;
        hitPos = POS_W'(w);
      end
    shiftLim = isHit ? hitPos : POS_W'(WAYS-1);
  end

  // Tag storage needs no reset: valid bits guard it.
  always_ff @(posedge clk) begin
    if (accEn) begin
      atdTag[accSet][0] <= accTag;
      for (int w = 1; w < WAYS; w++)
        if (POS_W'(w) <= shiftLim)
          atdTag[accSet][w] <= atdTag[accSet][w-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) atdVal[s] <= '0;
    end else if (accEn) begin
      atdVal[accSet][0] <= 1'b1;
      for (int w = 1; w < WAYS; w++)
        if (POS_W'(w) <= shiftLim)
          atdVal[accSet][w] <= atdVal[accSet][w-1];
    end
  end

  // Depth counters: halve first, then add a concurrent hit, saturating.
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      nextCnt[w] = halve ? (hitCnt[w] >> 1) : hitCnt[w];
      if (accEn && isHit && (hitPos == POS_W'(w)) && (nextCnt[w] != CNT_MAX))
        nextCnt[w] = nextCnt[w] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hitCnt <= '0;
    else       hitCnt <= nextCnt;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_chk
    AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
      !halve |=> hitCnt[w] >= $past(hitCnt[w]));                            // R3
    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
      !halve |=> {1'b0, hitCnt[w]} <= {1'b0, $past(hitCnt[w])} + 1'b1);      // R2
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (!halve && !accEn) |=> $stable(hitCnt[w]));                           // R2
  end
endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
#(
  parameter int WAYS      = 16,
  parameter int EPOCH_LEN = 5000000,
  localparam int CW = $clog2(WAYS),
  localparam int EW = $clog2(EPOCH_LEN)
) (
  input  logic          clk,
  input  logic          rstN,
  output wpStrobe_t     st,
  output logic [CW-1:0] cand,
  output logic          evalDone
);
  // EPOCH_LEN must exceed WAYS so an evaluation ends before the next snapshot.
  logic [EW-1:0] epochCnt;
  logic          evalActive;
  logic          epochEnd;

  assign epochEnd = (epochCnt == EW'(EPOCH_LEN-1));

  always_comb begin
    st.snap      = epochEnd;
    st.evalStep  = evalActive;
    st.evalFirst = evalActive && (cand == CW'(1));
    st.evalLast  = evalActive && (cand == CW'(WAYS-1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epochCnt   <= '0;
      evalActive <= 1'b0;
      cand       <= '0;
      evalDone   <= 1'b0;
    end else begin
      epochCnt <= epochEnd ? '0 : epochCnt + EW'(1);
      evalDone <= st.evalLast;
      if (epochEnd) begin
        evalActive <= 1'b1;
        cand       <= CW'(1);
      end else if (evalActive) begin
        if (cand == CW'(WAYS-1)) evalActive <= 1'b0;
        else                     cand       <= cand + CW'(1);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    evalDone |=> !evalDone);                                                // R6
  AST_SNAP_STARTS_EVAL: assert property (@(posedge clk) disable iff (!rstN)
    st.snap |=> (evalActive && cand == CW'(1) && !st.snap));                 // R6
endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int SETS  = 32,
  parameter int TAG_W = 16,
  parameter int CNT_W = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int CW    = $clog2(WAYS),
  localparam int QW    = $clog2(WAYS+1),
  localparam int SUM_W = CNT_W + CW + 1,
  localparam int TOT_W = SUM_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wpStrobe_t            st,
  input  logic [CW-1:0]        cand,
  input  logic                 accValid,
  input  logic                 accCore,
  input  logic                 accSampled,
  input  logic [SET_W-1:0]     accSet,
  input  logic [TAG_W-1:0]     accTag,
  input  logic                 vicCore,
  input  logic [WAYS-1:0]      vicOwner,
  input  logic [WAYS*CW-1:0]   vicRank,
  output logic [CW-1:0]        vicWay,
  output logic [QW-1:0]        quota0,
  output logic [QW-1:0]        quota1
);
  logic [1:0][WAYS-1:0][CNT_W-1:0] liveCnt;
  logic [1:0][WAYS-1:0][CNT_W-1:0] snapCnt;

  for (genvar c = 0; c < 2; c++) begin : g_core
    logic coreEn;
    assign coreEn = accValid && accSampled && (accCore == 1'(c));
    wp_monitor #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_mon (
      .clk(clk), .rstN(rstN), .accEn(coreEn), .accSet(accSet), .accTag(accTag),
      .halve(st.snap), .hitCnt(liveCnt[c]));
  end

  always_ff @(posedge clk) begin
    if (!rstN)        snapCnt <= '0;
    else if (st.snap) snapCnt <= liveCnt;
  end

  // Prefix sums over the snapshot: pre[c][n] is the hit count with n ways.
  logic [SUM_W-1:0] pre [2][WAYS+1];
  always_comb begin
    for (int c = 0; c < 2; c++) begin
      pre[c][0] = '0;
      for (int n = 1; n <= WAYS; n++)
        pre[c][n] = pre[c][n-1] + SUM_W'(snapCnt[c][n-1]);
    end
  end

  logic [CW:0]      otherWays;
  logic [TOT_W-1:0] candSum;
  logic [TOT_W-1:0] bestSum;
  logic [CW-1:0]    bestA;
  logic             takeCand;
  logic [CW-1:0]    winA;

  assign otherWays = (CW+1)'(WAYS) - {1'b0, cand};
  assign candSum   = TOT_W'(pre[0][cand]) + TOT_W'(pre[1][otherWays]);
  assign takeCand  = st.evalFirst || (candSum > bestSum);
  assign winA      = takeCand ? cand : bestA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestSum <= '0;
      bestA   <= '0;
      quota0  <= QW'(WAYS/2);
      quota1  <= QW'(WAYS - WAYS/2);
    end else if (st.evalStep) begin
      if (takeCand) begin
        bestSum <= candSum;
        bestA   <= cand;
      end
      if (st.evalLast) begin
        quota0 <= QW'(winA);
        quota1 <= QW'(WAYS) - QW'(winA);
      end
    end
  end

  // Victim selection for the main cache set.
  logic [WAYS-1:0] ownMask;
  logic [WAYS-1:0] clsRaw;
  logic [WAYS-1:0] cls;
  logic [QW-1:0]   ownCnt;
  logic [QW-1:0]   quotaSel;
  logic [CW-1:0]   bestRank;
  logic            found;

  always_comb begin
    ownCnt = '0;
    for (int w = 0; w < WAYS; w++) begin
      ownMask[w] = (vicOwner[w] == vicCore);
      ownCnt     = ownCnt + QW'(ownMask[w]);
    end
    quotaSel = vicCore ? quota1 : quota0;
    clsRaw   = (ownCnt < quotaSel) ? ~ownMask : ownMask;
    cls      = (clsRaw == '0) ? '1 : clsRaw;   // defensive: never empty
    found    = 1'b0;
    bestRank = '0;
    vicWay   = '0;
    for (int w = 0; w < WAYS; w++)
      if (cls[w] && (!found || vicRank[w*CW +: CW] > bestRank)) begin
        found    = 1'b1;
        bestRank = vicRank[w*CW +: CW];
        vicWay   = CW'(w);
      end
  end

  AST_QUOTA_SUM: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, quota0} + {1'b0, quota1}) == (QW+1)'(WAYS));                    // R6
  AST_QUOTA_MIN: assert property (@(posedge clk) disable iff (!rstN)
    (quota0 != '0) && (quota1 != '0));                                      // R6
  AST_QUOTA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.evalLast |=> $stable(quota0) && $stable(quota1));                   // R6
  AST_VICTIM_OTHER: assert property (@(posedge clk) disable iff (!rstN)
    (QW'($countones(vicOwner ^ {WAYS{~vicCore}})) < (vicCore ? quota1 : quota0))
      |-> (vicOwner[vicWay] != vicCore));                                   // R7
  AST_VICTIM_OWN: assert property (@(posedge clk) disable iff (!rstN)
    (QW'($countones(vicOwner ^ {WAYS{~vicCore}})) >= (vicCore ? quota1 : quota0))
      |-> (vicOwner[vicWay] == vicCore));                                   // R8
endmodule

// File: rtl/way_partitioner.sv
module way_partitioner
  import wp_pkg::*;
#(
  parameter int WAYS        = 16,
  parameter int SAMPLE_SETS = 32,
  parameter int TAG_W       = 16,
  parameter int CNT_W       = 16,
  parameter int EPOCH_LEN   = 5000000,
  localparam int SET_W = $clog2(SAMPLE_SETS),
  localparam int CW    = $clog2(WAYS),
  localparam int QW    = $clog2(WAYS+1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic               accCore,
  input  logic               accSampled,
  input  logic [SET_W-1:0]   accSet,
  input  logic [TAG_W-1:0]   accTag,
  input  logic               vicCore,
  input  logic [WAYS-1:0]    vicOwner,
  input  logic [WAYS*CW-1:0] vicRank,
  output logic [CW-1:0]      vicWay,
  output logic [QW-1:0]      quota0,
  output logic [QW-1:0]      quota1,
  output logic               evalDone
);
  wpStrobe_t     st;
  logic [CW-1:0] cand;

  wp_control #(.WAYS(WAYS), .EPOCH_LEN(EPOCH_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .st(st), .cand(cand), .evalDone(evalDone));

  wp_datapath #(.WAYS(WAYS), .SETS(SAMPLE_SETS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cand(cand),
    .accValid(accValid), .accCore(accCore), .accSampled(accSampled),
    .accSet(accSet), .accTag(accTag),
    .vicCore(vicCore), .vicOwner(vicOwner), .vicRank(vicRank), .vicWay(vicWay),
    .quota0(quota0), .quota1(quota1));
endmodule

// File: tb/way_partitioner_bench.sv
`timescale 1ns/1ps
module way_partitioner_bench;
  localparam int WAYS  = 16;
  localparam int SETS  = 4;
  localparam int TAG_W = 8;
  localparam int CNT_W = 6;
  localparam int EPOCH = 400;
  localparam int CW    = $clog2(WAYS);
  localparam int QW    = $clog2(WAYS+1);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accCore = 1'b0, accSampled = 1'b0;
  logic [$clog2(SETS)-1:0] accSet = '0;
  logic [TAG_W-1:0] accTag = '0;
  logic vicCore = 1'b0;
  logic [WAYS-1:0] vicOwner = '0;
  logic [WAYS*CW-1:0] vicRank = '0;
  logic [CW-1:0] vicWay;
  logic [QW-1:0] quota0, quota1;
  logic evalDone;

  always #2.5 clk = ~clk;

  way_partitioner #(.WAYS(WAYS), .SAMPLE_SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W),
                    .EPOCH_LEN(EPOCH)) u_way_partitioner (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accCore(accCore),
    .accSampled(accSampled), .accSet(accSet), .accTag(accTag),
    .vicCore(vicCore), .vicOwner(vicOwner), .vicRank(vicRank), .vicWay(vicWay),
    .quota0(quota0), .quota1(quota1), .evalDone(evalDone));

  int checks = 0, failures = 0;
  bit finished = 0;

  // Reference model state
  int stk [2][SETS][$];
  int hits [2][WAYS];
  int snapH [2][WAYS];
  int ecnt = 0, mCand = 0, q0 = WAYS/2, cyc = 0, lastDone = -1;
  bit evalOn = 0, doneM = 0;
  int rnk [WAYS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int bestSplit();
    int best = -1, ba = 1;
    for (int a = 1; a < WAYS; a++) begin
      int s = 0;
      for (int i = 0; i < a; i++) s += snapH[0][i];
      for (int i = 0; i < WAYS-a; i++) s += snapH[1][i];
      if (s > best) begin best = s; ba = a; end
    end
    return ba;
  endfunction

  task automatic modelStep(input bit v, input int c, input bit s, input int set, input int tag);
    bit doneN = evalOn && (mCand == WAYS-1);
    bit snapNow;
    if (evalOn) begin
      if (mCand == WAYS-1) begin q0 = bestSplit(); evalOn = 0; end
      else mCand++;
    end
    snapNow = (ecnt == EPOCH-1);
    ecnt = snapNow ? 0 : ecnt + 1;
    if (snapNow) begin
      for (int k = 0; k < 2; k++)
        for (int w = 0; w < WAYS; w++) begin
          snapH[k][w] = hits[k][w];
          hits[k][w]  = hits[k][w] / 2;
        end
      evalOn = 1; mCand = 1;
    end
    if (v && s) begin
      int p = -1;
      foreach (stk[c][set][i]) if (p < 0 && stk[c][set][i] == tag) p = i;
      if (p >= 0) begin
        if (hits[c][p] < CMAX) hits[c][p]++;
        stk[c][set].delete(p);
        stk[c][set].push_front(tag);
      end else begin
        stk[c][set].push_front(tag);
        if (stk[c][set].size() > WAYS) void'(stk[c][set].pop_back());
      end
    end
    doneM = doneN;
  endtask

  function automatic int refVictim(input int core, input logic [WAYS-1:0] own);
    int cnt = 0, q, bw = -1, br = -1;
    bit other;
    for (int w = 0; w < WAYS; w++) if (own[w] == core[0]) cnt++;
    q = core ? WAYS - q0 : q0;
    other = cnt < q;
    for (int w = 0; w < WAYS; w++)
      if (((own[w] == core[0]) != other) && rnk[w] > br) begin br = rnk[w]; bw = w; end
    return bw;
  endfunction

  // One clock: compare outputs, drive, optionally check victim, advance model.
  task automatic tick(input bit v, input int c, input bit s, input int set, input int tag,
                      input bit doVic, input int vc, input logic [WAYS-1:0] own,
                      input int expVic, input string vicReq);
    @(negedge clk);
    check(quota0 == QW'(q0), "R6 quota0", int'(quota0), q0);
    check(quota1 == QW'(WAYS - q0), "R6 quota1", int'(quota1), WAYS - q0);
    check(evalDone == doneM, "R6 done", int'(evalDone), int'(doneM));
    if (evalDone) begin
      if (lastDone < 0) check(cyc == EPOCH + WAYS - 1, "R6 first done cycle", cyc, EPOCH + WAYS - 1);
      else check(cyc - lastDone == EPOCH, "R4 epoch spacing", cyc - lastDone, EPOCH);
      lastDone = cyc;
    end
    rstN = 1'b1;
    accValid = v; accCore = c[0]; accSampled = s;
    accSet = set[$clog2(SETS)-1:0]; accTag = tag[TAG_W-1:0];
    if (doVic) begin
      vicCore = vc[0]; vicOwner = own;
      for (int w = 0; w < WAYS; w++) vicRank[w*CW +: CW] = CW'(rnk[w]);
      #1;
      check(int'(vicWay) == expVic, vicReq, int'(vicWay), expVic);
    end
    modelStep(v, c, s, set, tag);
    @(posedge clk);
    cyc++;
  endtask

  task automatic runMode(input int mode, input int n);
    int k0 = 0, k1 = 0;
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: if (i % 3 == 2) begin tick(1, 1, 1, 0, 100 + k1 % 4, 0, 0, '0, 0, ""); k1++; end
           else begin tick(1, 0, 1, 0, k0 % 14, 0, 0, '0, 0, ""); k0++; end
        1: if (i % 2 == 1) begin tick(1, 1, 1, 0, 120 + k1 % 2, 0, 0, '0, 0, ""); k1++; end
           else begin tick(1, 0, 1, 0, 20 + k0 % 12, 0, 0, '0, 0, ""); k0++; end
        default:
          case (i % 4)
            0: begin tick(1, 0, 1, 0, 40 + k0 % 3, 0, 0, '0, 0, ""); k0++; end
            2: tick(1, 0, 0, 0, 20 + (i / 4) % 12, 0, 0, '0, 0, "");  // R2: not sampled
            default: begin tick(1, 1, 1, 1, 140 + k1 % 10, 0, 0, '0, 0, ""); k1++; end
          endcase
      endcase
    end
  endtask

  task automatic vic(input int vc, input logic [WAYS-1:0] own, input int expVic, input string req);
    tick(0, 0, 0, 0, 0, 1, vc, own, expVic, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset values
    @(negedge clk);
    check(quota0 == QW'(WAYS/2), "R1 quota0 reset", int'(quota0), WAYS/2);
    check(quota1 == QW'(WAYS/2), "R1 quota1 reset", int'(quota1), WAYS/2);
    check(evalDone == 1'b0, "R1 done reset", int'(evalDone), 0);
    // R1/R8: core 0 owns 8 of 16 with quota 8 -> own LRU
    for (int w = 0; w < WAYS; w++) rnk[w] = w;
    vic(0, 16'hFF00, 7, "R8 victim at reset quota");

    // R3/R5: saturation makes both cores tie at the max -> smallest a
    runMode(0, EPOCH + 20);
    check(quota0 == QW'(1), "R3 saturated tie picks a=1", int'(quota0), 1);
    // R2/R5: core 0 needs 12 ways, core 1 needs 2 -> ties 12..14 -> 12
    runMode(1, 6 * EPOCH);
    check(quota0 == QW'(12), "R5 split 12", int'(quota0), 12);
    // R2/R4: core 0 needs 3, core 1 needs 10; old hits decay; unsampled ignored
    runMode(2, 8 * EPOCH);
    check(quota0 == QW'(3), "R2 R4 split 3", int'(quota0), 3);
    check(quota1 == QW'(13), "R6 quota1 13", int'(quota1), 13);

    // Victim cases with quota0=3, quota1=13
    for (int w = 0; w < WAYS; w++) rnk[w] = w;
    vic(0, 16'hFFFC, 15, "R7 core0 below quota");
    vic(1, 16'h7FFF, 14, "R8 core1 at or above quota");
    for (int w = 0; w < WAYS; w++) rnk[w] = WAYS - 1 - w;
    vic(0, 16'hFFE0, 0, "R8 core0 above quota");
    for (int w = 0; w < WAYS; w++) rnk[w] = (w + 2) % WAYS;
    vic(1, 16'h0FFF, 13, "R7 core1 below quota");
    for (int w = 0; w < WAYS; w++) rnk[w] = 0;
    vic(0, 16'hFFFC, 2, "R9 equal ranks lowest index");
    // Pseudo-random permutations
    for (int t = 0; t < 24; t++) begin
      logic [WAYS-1:0] own = WAYS'($urandom);
      int vc = t % 2;
      for (int w = 0; w < WAYS; w++) rnk[w] = w;
      for (int w = WAYS-1; w > 0; w--) begin
        int j = $urandom % (w + 1);
        int tmp = rnk[w]; rnk[w] = rnk[j]; rnk[j] = tmp;
      end
      vic(vc, own, refVictim(vc, own), "R7 R8 random victim");
    end
    tick(0, 0, 0, 0, 0, 0, 0, '0, 0, "");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule